// File: doc/BRIEF.md
# Delayed Branch and Annul Resolver

This block resolves one control-transfer instruction per cycle for a 32-bit RISC pipeline with a single delay slot. It takes the instruction word, its PC, the four integer condition flags and the two operands of a register-indirect jump. One cycle later it reports three things. The first is whether the instruction in the delay slot executes or is annulled. The second is the fetch address that follows the slot. The third is the link-register write for calls and jumps. Instructions that transfer no control pass through as plain sequential flow.

Three instruction classes are recognised. A conditional branch evaluates one of sixteen conditions over N, Z, V and C and has a PC-relative target. A call has a PC-relative target and always links to a fixed register. A jump-and-link adds two register operands to form its target and links to the register its own instruction names. Two wrapping event counters run beside the decision logic: one counts transfers that were taken, the other counts delay slots that were skipped.

Top module: `ctl_xfer_resolver`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `out_valid`, `out_xfer`, `out_taken`, `slot_exec` and `link_we` are 0 and both counters are 0.
- R2: A conditional branch (bits 31:30 = 0, bits 24:22 = 2) takes its condition from bits 28:25. `flags` is {N,Z,V,C}, with N at bit 3 and C at bit 0. The codes are: 0 never; 1 Z; 2 Z|(N^V); 3 N^V; 4 C|Z; 5 C; 6 N; 7 V.
- R3: Codes 8 to 15 are the complements of codes 0 to 7 in the same order, so code 8 is always taken and code 9 is taken when Z is clear.
- R4: A taken branch's `next_pc` is the branch PC plus (bits 21:0 sign-extended from bit 21, shifted left by 2).
- R5: An untaken branch gives `next_pc` = PC+8. Its `slot_exec` is the inverse of the annul bit, instruction bit 29.
- R6: A taken branch gives `slot_exec` = 1, except when the code is 8 and bit 29 is set; that case gives `slot_exec` = 0.
- R7: A call (bits 31:30 = 1) targets PC + (bits 29:0 shifted left by 2). It is always taken and always executes its slot. It writes its own PC to register 15 (`link_we` = 1, `link_idx` = 15, `link_val` = PC).
- R8: A jump-and-link (bits 31:30 = 2, bits 24:19 = 0x38) targets `rs1_val` + `op2_val`. It is always taken and always executes its slot. It writes its own PC to the register named in bits 29:25, and `link_we` stays 0 when that index is 0.
- R9: Any other instruction gives `out_xfer` = 0, `out_taken` = 0, `slot_exec` = 1, `next_pc` = PC+8 and `link_we` = 0, and leaves both counters unchanged.
- R10: `taken_cnt` rises by one for every taken branch, call or jump. `annul_cnt` rises by one for every skipped slot. Both wrap modulo 2^CNT_W.
- R11: All outputs reflect the instruction presented with `in_valid` one clock earlier. A cycle without `in_valid` gives `out_valid` = 0, `link_we` = 0, and counters that hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| pc | input | XLEN | PC of the instruction |
| flags | input | 4 | {N,Z,V,C} condition flags |
| rs1_val | input | XLEN | First jump operand |
| op2_val | input | XLEN | Second jump operand |
| out_valid | output | 1 | Result below is valid |
| out_xfer | output | 1 | Instruction was a control transfer |
| out_taken | output | 1 | Transfer was taken |
| slot_exec | output | 1 | Delay-slot instruction executes |
| next_pc | output | XLEN | Fetch address after the slot |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link register index |
| link_val | output | XLEN | Link value (own PC) |
| taken_cnt | output | CNT_W | Taken transfer counter |
| annul_cnt | output | CNT_W | Skipped slot counter |

## Verification
The block holds no state except its output register and the two counters. A decode or condition fault therefore shows at the ports in the very next cycle as a wrong `slot_exec`, `next_pc` or link field. A counter that steps wrongly stays wrong from then on, so comparing both counters after every instruction pins the fault to the instruction that caused it. The branch-always-with-annul case and the untaken annulled case are the only paths that clear `slot_exec`, and each is exercised directly and in the mixed stream.

// File: rtl/ctl_xfer_pkg.sv
package ctl_xfer_pkg;

   typedef enum logic [1:0] {
      XK_NONE   = 2'd0,
      XK_BRANCH = 2'd1,
      XK_CALL   = 2'd2,
      XK_JUMP   = 2'd3
   } xfer_kind_e;

   localparam int unsigned REG_IDX_W = 5;
   localparam int unsigned COND_W    = 4;
   localparam int unsigned FLAG_W    = 4;

   localparam int unsigned FLAG_N = 3;
   localparam int unsigned FLAG_Z = 2;
   localparam int unsigned FLAG_V = 1;
   localparam int unsigned FLAG_C = 0;

   localparam logic [1:0] TOP_BRANCH = 2'd0;
   localparam logic [1:0] TOP_CALL   = 2'd1;
   localparam logic [1:0] TOP_ALU    = 2'd2;
   localparam logic [2:0] SUB_BRANCH = 3'd2;
   localparam logic [5:0] SUB_JUMP   = 6'h38;
   localparam logic [COND_W-1:0] COND_ALWAYS = 4'd8;

   typedef struct packed {
      xfer_kind_e            kind;
      logic [COND_W-1:0]     cond;
      logic                  annul;
      logic [REG_IDX_W-1:0]  rd;
   } xfer_dec_t;

endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
   import ctl_xfer_pkg::*;
(
   input  logic [31:0] instr,
   output xfer_dec_t   dec
);

   logic [1:0] top;
   logic       is_branch;
   logic       is_call;
   logic       is_jump;

   assign top       = instr[31:30];
   assign is_branch = (top == TOP_BRANCH) && (instr[24:22] == SUB_BRANCH);
   assign is_call   = (top == TOP_CALL);
   assign is_jump   = (top == TOP_ALU) && (instr[24:19] == SUB_JUMP);

   always_comb begin
      dec.cond  = instr[28:25];
      dec.annul = instr[29];
      dec.rd    = instr[29:25];
      if (is_branch)      dec.kind = XK_BRANCH;
      else if (is_call)   dec.kind = XK_CALL;
      else if (is_jump)   dec.kind = XK_JUMP;
      else                dec.kind = XK_NONE;
   end

   always_comb begin
      assert_kind_onehot_R9: assert ($onehot0({is_branch, is_call, is_jump}));
   end

endmodule

// File: rtl/cond_eval.sv
module cond_eval
   import ctl_xfer_pkg::*;
#(
   parameter int unsigned IMPL = 0
)(
   input  logic [COND_W-1:0] cond,
   input  logic [FLAG_W-1:0] flags,
   output logic              take
);

   logic n, z, v, c;
   assign n = flags[FLAG_N];
   assign z = flags[FLAG_Z];
   assign v = flags[FLAG_V];
   assign c = flags[FLAG_C];

   if (IMPL > 1) begin : g_bad_impl
      $error("cond_eval: IMPL must be 0 or 1");
   end

   if (IMPL == 0) begin : g_folded
      logic base;
      always_comb begin
         unique case (cond[2:0])
            3'd0:    base = 1'b0;
            3'd1:    base = z;
            3'd2:    base = z | (n ^ v);
            3'd3:    base = n ^ v;
            3'd4:    base = c | z;
            3'd5:    base = c;
            3'd6:    base = n;
            default: base = v;
         endcase
      end
      assign take = cond[3] ^ base;
   end else begin : g_flat
      always_comb begin
         unique case (cond)
            4'd0:    take = 1'b0;
            4'd1:    take = z;
            4'd2:    take = z | (n ^ v);
            4'd3:    take = n ^ v;
            4'd4:    take = c | z;
            4'd5:    take = c;
            4'd6:    take = n;
            4'd7:    take = v;
            4'd8:    take = 1'b1;
            4'd9:    take = ~z;
            4'd10:   take = ~(z | (n ^ v));
            4'd11:   take = ~(n ^ v);
            4'd12:   take = ~(c | z);
            4'd13:   take = ~c;
            4'd14:   take = ~n;
            default: take = ~v;
         endcase
      end
   end

endmodule

// File: rtl/target_gen.sv
module target_gen
   import ctl_xfer_pkg::*;
#(
   parameter int unsigned XLEN = 32
)(
   input  xfer_kind_e       kind,
   input  logic [31:0]      instr,
   input  logic [XLEN-1:0]  pc,
   input  logic [XLEN-1:0]  rs1_val,
   input  logic [XLEN-1:0]  op2_val,
   output logic [XLEN-1:0]  target,
   output logic [XLEN-1:0]  seq_pc
);

   localparam int unsigned BR_EXT = XLEN - 24;

   logic [XLEN-1:0] br_off;
   logic [XLEN-1:0] call_off;

   assign br_off = {{BR_EXT{instr[21]}}, instr[21:0], 2'b00};

   if (XLEN == 32) begin : g_call_native
      assign call_off = {instr[29:0], 2'b00};
   end else begin : g_call_wide
      assign call_off = {{(XLEN-32){instr[29]}}, instr[29:0], 2'b00};
   end

   always_comb begin
      unique case (kind)
         XK_BRANCH: target = pc + br_off;
         XK_CALL:   target = pc + call_off;
         XK_JUMP:   target = rs1_val + op2_val;
         default:   target = pc + XLEN'(8);
      endcase
   end

   assign seq_pc = pc + XLEN'(8);

endmodule

// File: rtl/event_counter.sv
module event_counter #(
   parameter int unsigned CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (inc) cnt <= cnt + CNT_W'(1);
   end

   assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      inc |=> (cnt == $past(cnt) + CNT_W'(1)));

   assert_cnt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(cnt));

endmodule

// File: rtl/ctl_xfer_resolver.sv
module ctl_xfer_resolver
   import ctl_xfer_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned LINK_REG  = 15,
   parameter int unsigned COND_IMPL = 0
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [31:0]           instr,
   input  logic [XLEN-1:0]       pc,
   input  logic [3:0]            flags,
   input  logic [XLEN-1:0]       rs1_val,
   input  logic [XLEN-1:0]       op2_val,
   output logic                  out_valid,
   output logic                  out_xfer,
   output logic                  out_taken,
   output logic                  slot_exec,
   output logic [XLEN-1:0]       next_pc,
   output logic                  link_we,
   output logic [4:0]            link_idx,
   output logic [XLEN-1:0]       link_val,
   output logic [CNT_W-1:0]      taken_cnt,
   output logic [CNT_W-1:0]      annul_cnt
);

   localparam logic [REG_IDX_W-1:0] LINK_IDX = REG_IDX_W'(LINK_REG);

   if (XLEN < 32) begin : g_bad_xlen
      $error("ctl_xfer_resolver: XLEN must be at least 32");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("ctl_xfer_resolver: CNT_W must be at least 1");
   end
   if (LINK_REG == 0 || LINK_REG >= (1 << REG_IDX_W)) begin : g_bad_link
      $error("ctl_xfer_resolver: LINK_REG must name a nonzero register");
   end

   xfer_dec_t       dec;
   logic            cond_take;
   logic [XLEN-1:0] target;
   logic [XLEN-1:0] seq_pc;

   logic                 take_c;
   logic                 slot_c;
   logic                 xfer_c;
   logic                 link_we_c;
   logic [REG_IDX_W-1:0] link_idx_c;
   logic [XLEN-1:0]      next_c;
   logic                 inc_taken;
   logic                 inc_annul;

   xfer_decode u_decode (
      .instr (instr),
      .dec   (dec)
   );

   cond_eval #(.IMPL(COND_IMPL)) u_cond (
      .cond  (dec.cond),
      .flags (flags),
      .take  (cond_take)
   );

   target_gen #(.XLEN(XLEN)) u_target (
      .kind    (dec.kind),
      .instr   (instr),
      .pc      (pc),
      .rs1_val (rs1_val),
      .op2_val (op2_val),
      .target  (target),
      .seq_pc  (seq_pc)
   );

   always_comb begin
      xfer_c     = (dec.kind != XK_NONE);
      take_c     = 1'b0;
      slot_c     = 1'b1;
      link_we_c  = 1'b0;
      link_idx_c = '0;
      unique case (dec.kind)
         XK_BRANCH: begin
            take_c = cond_take;
            if (cond_take) slot_c = !(dec.annul && (dec.cond == COND_ALWAYS));
            else           slot_c = !dec.annul;
         end
         XK_CALL: begin
            take_c     = 1'b1;
            link_we_c  = 1'b1;
            link_idx_c = LINK_IDX;
         end
         XK_JUMP: begin
            take_c     = 1'b1;
            link_we_c  = (dec.rd != '0);
            link_idx_c = dec.rd;
         end
         default: ;
      endcase
      next_c = take_c ? target : seq_pc;
   end

   assign inc_taken = in_valid && take_c;
   assign inc_annul = in_valid && !slot_c;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_xfer  <= 1'b0;
         out_taken <= 1'b0;
         slot_exec <= 1'b0;
         next_pc   <= '0;
         link_we   <= 1'b0;
         link_idx  <= '0;
         link_val  <= '0;
      end else if (in_valid) begin
         out_valid <= 1'b1;
         out_xfer  <= xfer_c;
         out_taken <= take_c;
         slot_exec <= slot_c;
         next_pc   <= next_c;
         link_we   <= link_we_c;
         link_idx  <= link_idx_c;
         link_val  <= pc;
      end else begin
         out_valid <= 1'b0;
         out_xfer  <= 1'b0;
         out_taken <= 1'b0;
         slot_exec <= 1'b0;
         link_we   <= 1'b0;
      end
   end

   event_counter #(.CNT_W(CNT_W)) u_taken_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc_taken),
      .cnt   (taken_cnt)
   );

   event_counter #(.CNT_W(CNT_W)) u_annul_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc_annul),
      .cnt   (annul_cnt)
   );

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (!out_valid && !link_we && taken_cnt == '0 && annul_cnt == '0));

   assert_untaken_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dec.kind == XK_BRANCH && !cond_take)
      |=> (next_pc == $past(pc) + XLEN'(8) && slot_exec == !$past(instr[29])));

   assert_always_annul_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dec.kind == XK_BRANCH && dec.cond == COND_ALWAYS && dec.annul)
      |=> (!slot_exec && out_taken));

   assert_call_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dec.kind == XK_CALL)
      |=> (link_we && link_idx == LINK_IDX && link_val == $past(pc) && slot_exec));

   assert_jump_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dec.kind == XK_JUMP)
      |=> (next_pc == $past(rs1_val) + $past(op2_val) && slot_exec && out_taken));

   assert_plain_flow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_xfer) |-> (slot_exec && !out_taken && !link_we));

   assert_annul_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !slot_exec) |-> (annul_cnt == $past(annul_cnt) + CNT_W'(1)));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !link_we));

endmodule

// File: tb/test_ctl_xfer_resolver.sv
module test_ctl_xfer_resolver;

   localparam int unsigned XLEN  = 32;
   localparam int unsigned CNT_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [31:0]      instr = '0;
   logic [XLEN-1:0]  pc = '0;
   logic [3:0]       flags = '0;
   logic [XLEN-1:0]  rs1_val = '0;
   logic [XLEN-1:0]  op2_val = '0;
   logic             out_valid, out_xfer, out_taken, slot_exec, link_we;
   logic [XLEN-1:0]  next_pc, link_val;
   logic [4:0]       link_idx;
   logic [CNT_W-1:0] taken_cnt, annul_cnt;

   int checks = 0;
   int errors = 0;
   int exp_taken = 0;
   int exp_annul = 0;
   logic [31:0] seed = 32'h1234_5677;

   always #4 clk = ~clk;

   ctl_xfer_resolver #(.XLEN(XLEN), .CNT_W(CNT_W)) i_ctl_xfer_resolver (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
      .flags(flags), .rs1_val(rs1_val), .op2_val(op2_val),
      .out_valid(out_valid), .out_xfer(out_xfer), .out_taken(out_taken),
      .slot_exec(slot_exec), .next_pc(next_pc), .link_we(link_we),
      .link_idx(link_idx), .link_val(link_val),
      .taken_cnt(taken_cnt), .annul_cnt(annul_cnt)
   );

   function automatic logic ref_cond(input logic [3:0] code, input logic [3:0] f);
      logic n, z, v, c;
      n = f[3]; z = f[2]; v = f[1]; c = f[0];
      case (code)
         4'd0:  return 1'b0;
         4'd1:  return z;
         4'd2:  return z || (n != v);
         4'd3:  return n != v;
         4'd4:  return c || z;
         4'd5:  return c;
         4'd6:  return n;
         4'd7:  return v;
         4'd8:  return 1'b1;
         4'd9:  return !z;
         4'd10: return !(z || (n != v));
         4'd11: return n == v;
         4'd12: return !(c || z);
         4'd13: return !c;
         4'd14: return !n;
         default: return !v;
      endcase
   endfunction

   function automatic logic [31:0] next_rand();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   task automatic note(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Present one instruction, then compare at the following falling edge.
   task automatic issue(input string tag, input logic [31:0] iw, input logic [31:0] p,
                        input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
      logic xf, tk, sl, lw;
      logic [31:0] np;
      logic [4:0] li;
      logic signed [31:0] boff;
      xf = 1'b0; tk = 1'b0; sl = 1'b1; lw = 1'b0; li = 5'd0; np = p + 32'd8;
      if (iw[31:30] == 2'd0 && iw[24:22] == 3'd2) begin
         xf = 1'b1;
         tk = ref_cond(iw[28:25], f);
         boff = 32'(signed'(iw[21:0])) * 4;
         if (tk) begin
            np = p + 32'(boff);
            sl = !(iw[29] && iw[28:25] == 4'd8);
         end else begin
            sl = !iw[29];
         end
      end else if (iw[31:30] == 2'd1) begin
         xf = 1'b1; tk = 1'b1; lw = 1'b1; li = 5'd15;
         np = p + (iw << 2);
      end else if (iw[31:30] == 2'd2 && iw[24:19] == 6'h38) begin
         xf = 1'b1; tk = 1'b1; li = iw[29:25]; lw = (li != 5'd0);
         np = a + b;
      end
      in_valid = 1'b1; instr = iw; pc = p; flags = f; rs1_val = a; op2_val = b;
      @(negedge clk);
      in_valid = 1'b0;
      if (tk) exp_taken = (exp_taken + 1) % 16;
      if (!sl) exp_annul = (exp_annul + 1) % 16;
      note(tag, "valid", 64'(out_valid), 64'(1'b1));
      note(tag, "decision", 64'({out_xfer, out_taken, slot_exec, link_we}),
           64'({xf, tk, sl, lw}));
      note(tag, "next_pc", 64'(next_pc), 64'(np));
      if (lw) begin
         note(tag, "link", 64'({link_idx, link_val}), 64'({li, p}));
      end
      note("R10", "counters", 64'({taken_cnt, annul_cnt}),
           64'({4'(exp_taken), 4'(exp_annul)}));
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         in_valid = 1'b0;
         @(negedge clk);
         note("R11", "idle valid/link", 64'({out_valid, link_we}), 64'(2'b00));
         note("R11", "idle counters", 64'({taken_cnt, annul_cnt}),
              64'({4'(exp_taken), 4'(exp_annul)}));
      end
   endtask

   function automatic logic [31:0] br(input logic a, input logic [3:0] c, input logic [21:0] d);
      return {2'b00, a, c, 3'b010, d};
   endfunction

   function automatic logic [31:0] jmp(input logic [4:0] rd);
      return {2'b10, rd, 6'h38, 19'h0};
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stimulus
      repeat (3) @(negedge clk);
      note("R1", "reset outputs", 64'({out_valid, out_xfer, out_taken, slot_exec, link_we}), 64'(0));
      note("R1", "reset counters", 64'({taken_cnt, annul_cnt}), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      note("R1", "after release", 64'({out_valid, link_we, taken_cnt, annul_cnt}), 64'(0));

      // R2 / R3: every condition code against every flag pattern
      for (int c = 0; c < 16; c++) begin
         for (int f = 0; f < 16; f++) begin
            issue(c < 8 ? "R2" : "R3", br(f[0], 4'(c), 22'h10), 32'h0000_1000, 4'(f), 0, 0);
         end
      end

      // R4: forward, backward and extreme displacements
      issue("R4", br(1'b0, 4'd8, 22'h000004), 32'h0000_4000, 4'h0, 0, 0);
      issue("R4", br(1'b0, 4'd8, 22'h3FFFFF), 32'h0000_4000, 4'h0, 0, 0);
      issue("R4", br(1'b0, 4'd8, 22'h200000), 32'h8000_0000, 4'h0, 0, 0);
      issue("R4", br(1'b0, 4'd8, 22'h1FFFFF), 32'h0000_0010, 4'h0, 0, 0);

      // R5: untaken, with and without annul
      issue("R5", br(1'b1, 4'd0, 22'h55), 32'h0000_2000, 4'h0, 0, 0);
      issue("R5", br(1'b0, 4'd1, 22'h55), 32'h0000_2000, 4'h0, 0, 0);
      issue("R5", br(1'b1, 4'd9, 22'h55), 32'h0000_2000, 4'h4, 0, 0);

      // R6: taken; branch-always with annul skips the slot
      issue("R6", br(1'b1, 4'd8, 22'h20), 32'h0000_3000, 4'h0, 0, 0);
      issue("R6", br(1'b1, 4'd1, 22'h20), 32'h0000_3000, 4'h4, 0, 0);
      issue("R6", br(1'b0, 4'd8, 22'h20), 32'h0000_3000, 4'h0, 0, 0);

      // R7: calls, including a backward target
      issue("R7", {2'b01, 30'h0000_0040}, 32'h0000_5000, 4'hF, 0, 0);
      issue("R7", {2'b01, 30'h3FFF_FFF0}, 32'h0000_5000, 4'h0, 0, 0);

      // R8: jumps, linking and non-linking
      issue("R8", jmp(5'd7), 32'h0000_6000, 4'h0, 32'h1000_0000, 32'h0000_0008);
      issue("R8", jmp(5'd0), 32'h0000_6004, 4'h0, 32'hFFFF_FFFC, 32'h0000_0010);
      issue("R8", jmp(5'd31), 32'h0000_6008, 4'h0, 32'h0000_0100, 32'hFFFF_FF00);

      // R9: non-transfer instructions, including near-miss encodings
      issue("R9", 32'h8000_0000, 32'h0000_7000, 4'hF, 1, 2);
      issue("R9", {2'b00, 1'b1, 4'd8, 3'b100, 22'h3}, 32'h0000_7000, 4'h0, 0, 0);
      issue("R9", {2'b10, 5'd1, 6'h39, 19'h0}, 32'h0000_7000, 4'h0, 5, 6);
      issue("R9", 32'hC000_0000, 32'h0000_7000, 4'h0, 0, 0);

      // R11: gaps between instructions
      idle(3);
      issue("R11", br(1'b1, 4'd8, 22'h1), 32'h0000_8000, 4'h0, 0, 0);
      idle(2);

      // Mixed stream, counters wrap through R10
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] r, iw;
         r = next_rand();
         case (r[1:0])
            2'd0: iw = br(r[2], r[6:3], next_rand() & 32'h003F_FFFF);
            2'd1: iw = {2'b01, next_rand() & 32'h3FFF_FFFF} & 32'h7FFF_FFFF;
            2'd2: iw = jmp(r[7:3]);
            default: iw = next_rand();
         endcase
         issue("R10", iw, next_rand() & 32'hFFFF_FFFC, r[11:8], next_rand(), next_rand());
         if (r[15:12] == 4'd0) idle(1);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule